// File: doc/BRIEF.md
# Tagged Shared Receive Silo

This block gathers received characters from eight serial line receivers into one shared first-in first-out store. Every stored word is tagged with the line it came from and with that character's parity-error and framing-error flags. A framing error is also how a received break appears, so each error flag stays in the same word as its character. Each line also has a carrier-detect input. When a line's carrier input changes and modem interrupts are enabled for that line, a marker word for that line goes into the same store, in arrival order with the characters.

Software reads the store through one 16-bit receive word. The head word is always shown on `rd_data`, and a read strobe removes it. When the store is empty, the word reads as zero, so software keeps reading until bit 15 is clear. Each line has a one-word holding register. When several lines deliver in the same cycle, they are moved into the store one per cycle, lowest line first. A character that is lost, either because the store is full or because its line's holding register is still occupied, sets an overrun flag. That flag is written into the next stored word and then cleared. A receive interrupt is raised while words are waiting and the interrupt is enabled.

Top module: `rx_silo_hub`

## Requirements
- R1: A stored word has this layout: bit 15 valid (always 1 in a stored word), bit 14 overrun, bit 13 framing error, bit 12 parity error, bit 11 carrier-change marker, bits 10:8 source line, bits 7:0 character.
- R2: `rd_data` shows the oldest word. A cycle with `rd_stb` high removes that word. When the store is empty, `rd_data` is 0 and a strobe has no effect.
- R3: Words are stored in arrival order, at most one per cycle. Among pending requests, a lower line goes first, and within a line a character goes before a carrier marker. An input sampled at clock edge N appears on `rd_data` after edge N+1 when nothing else is pending.
- R4: A change of `dcd[i]` while `mdm_ie[i]` is 1 stores a marker word with bit 11 set, the line number in bits 10:8, and bits 13:12 and 7:0 zero. A change while `mdm_ie[i]` is 0 stores nothing. The carrier history is 0 after reset.
- R5: A character from line i is accepted only when `rx_en[i]` is 1.
- R6: The `rx_perr` and `rx_ferr` flags given with a character are stored in bits 12 and 13 of that character's own word.
- R7: The store holds 64 words. A pending word that finds the store full is dropped and sets the overrun flag. The next stored word carries bit 14 set, and the flag then clears.
- R8: A character arriving on a line whose holding register is occupied and not being drained in that cycle is dropped and sets the overrun flag.
- R9: `rx_irq` is 1 exactly when `rx_ie` is 1 and the store is not empty. `ctl_stat` bit 7 is "not empty", bit 6 echoes `rx_ie`, and bits 5:0 are 0.
- R10: `master_clr` empties the store, the holding registers and the pending markers, and clears the overrun flag, all at the next edge.
- R11: After reset the store is empty: `rd_data` is 0, `rx_irq` is 0 and `ctl_stat` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_clr | input | 1 | Synchronous clear of store, holding registers and overrun flag |
| rx_vld | input | 8 | Per-line character strobe |
| rx_data | input | 64 | Per-line character, line i in bits 8i+7:8i |
| rx_perr | input | 8 | Per-line parity error with the character |
| rx_ferr | input | 8 | Per-line framing error (break) with the character |
| rx_en | input | 8 | Per-line receive enable |
| dcd | input | 8 | Per-line carrier detect |
| mdm_ie | input | 8 | Per-line modem change enable |
| rx_ie | input | 1 | Receive interrupt enable |
| rd_stb | input | 1 | Read strobe, removes the head word |
| rd_data | output | 16 | Head word, or 0 when empty |
| ctl_stat | output | 8 | Bit 7 not empty, bit 6 interrupt enable |
| rx_irq | output | 1 | Receive interrupt |

## Verification
An input sampled at one clock edge is in a holding register after that edge. With nothing ahead of it, it reaches `rd_data` after the following edge, and each lower-numbered line that is pending at the same time delays it by one more edge. A read strobe, a clear and the interrupt all take effect at the next edge. The bench drives inputs just after a falling edge and advances its reference model once per rising edge. It samples and compares `rd_data`, `rx_irq` and `ctl_stat` at the next falling edge. Directed checks of latency, ordering and overrun placement are sampled at exactly those falling edges, counted from the edge that captured the stimulus.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int CHR_W  = 8;
  localparam int WORD_W = 16;

  typedef struct packed {
    logic            vld;
    logic            ovr;
    logic            fe;
    logic            pe;
    logic            dsc;
    logic [2:0]      line;
    logic [CHR_W-1:0] ch;
  } rx_word_t;

  typedef struct packed {
    logic             pe;
    logic             fe;
    logic [CHR_W-1:0] ch;
  } rx_char_t;

  // Builds a stored word; markers carry no character or error flags.
  function automatic rx_word_t make_word(logic ovr, logic is_mark,
                                         logic [2:0] line, rx_char_t c);
    rx_word_t w;
    w.vld  = 1'b1;
    w.ovr  = ovr;
    w.dsc  = is_mark;
    w.line = line;
    w.fe   = is_mark ? 1'b0 : c.fe;
    w.pe   = is_mark ? 1'b0 : c.pe;
    w.ch   = is_mark ? '0 : c.ch;
    return w;
  endfunction

  // Next overrun flag: a drop sets it, a store that carried it clears it.
  function automatic logic next_ovr(logic cur, logic dropped, logic stored);
    return dropped | (cur & ~stored);
  endfunction
endpackage

// File: rtl/rxs_line_hold.sv
module rxs_line_hold
  import rxs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  logic     in_vld,
  input  logic     in_en,
  input  rx_char_t in_chr,
  input  logic     car,
  input  logic     car_ie,
  input  logic     take_chr,
  input  logic     take_mark,
  output logic     chr_full,
  output rx_char_t chr_word,
  output logic     mark_pend,
  output logic     collide
);
  logic arrive, load, car_q, car_chg;

  assign arrive  = in_vld & in_en;
  assign load    = arrive & (~chr_full | take_chr);
  assign collide = arrive & chr_full & ~take_chr & ~clr;
  assign car_chg = car_ie & (car ^ car_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chr_full  <= 1'b0;
      chr_word  <= '0;
      mark_pend <= 1'b0;
      car_q     <= 1'b0;
    end else begin
      car_q <= car;
      if (clr) begin
        chr_full  <= 1'b0;
        mark_pend <= 1'b0;
      end else begin
        if (load) begin
          chr_full <= 1'b1;
          chr_word <= in_chr;
        end else if (take_chr) begin
          chr_full <= 1'b0;
        end
        if (car_chg)        mark_pend <= 1'b1;
        else if (take_mark) mark_pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rxs_pick.sv
module rxs_pick #(
  parameter int REQS = 16,
  localparam int IW  = $clog2(REQS)
) (
  input  logic [REQS-1:0] req,
  output logic [REQS-1:0] gnt,
  output logic [IW-1:0]   idx,
  output logic            any
);
  always_comb begin
    idx = '0;
    for (int k = REQS - 1; k >= 0; k--) begin
      if (req[k]) idx = IW'(k);
    end
    any = |req;
    gnt = any ? (REQS'(1) << idx) : '0;
  end
endmodule

// File: rtl/rxs_store.sv
module rxs_store #(
  parameter int DEPTH = 64,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rx_silo_hub.sv
module rx_silo_hub
  import rxs_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int DEPTH     = 64,
  localparam int REQS     = 2 * NUM_LINES,
  localparam int IW       = $clog2(REQS),
  localparam int LW       = IW - 1,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       master_clr,
  input  logic [NUM_LINES-1:0]       rx_vld,
  input  logic [NUM_LINES*CHR_W-1:0] rx_data,
  input  logic [NUM_LINES-1:0]       rx_perr,
  input  logic [NUM_LINES-1:0]       rx_ferr,
  input  logic [NUM_LINES-1:0]       rx_en,
  input  logic [NUM_LINES-1:0]       dcd,
  input  logic [NUM_LINES-1:0]       mdm_ie,
  input  logic                       rx_ie,
  input  logic                       rd_stb,
  output logic [WORD_W-1:0]          rd_data,
  output logic [7:0]                 ctl_stat,
  output logic                       rx_irq
);
  rx_char_t             chr_w   [NUM_LINES];
  logic [NUM_LINES-1:0] chr_full, mark_pend, collide;
  logic [REQS-1:0]      req, gnt;
  logic [IW-1:0]        win;
  logic                 any_req;
  logic [LW-1:0]        win_line;
  logic                 win_mark;
  rx_word_t             new_word;
  logic                 push, pop, drop_full, drop_any, ovr_q;
  logic                 empty, full;
  logic [CW-1:0]        count;
  logic [WORD_W-1:0]    head;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    rx_char_t c_in;
    assign c_in.pe = rx_perr[i];
    assign c_in.fe = rx_ferr[i];
    assign c_in.ch = rx_data[i*CHR_W +: CHR_W];
    assign req[2*i]     = chr_full[i];
    assign req[2*i + 1] = mark_pend[i];

    rxs_line_hold u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (master_clr),
      .in_vld    (rx_vld[i]),
      .in_en     (rx_en[i]),
      .in_chr    (c_in),
      .car       (dcd[i]),
      .car_ie    (mdm_ie[i]),
      .take_chr  (gnt[2*i] & ~master_clr),
      .take_mark (gnt[2*i + 1] & ~master_clr),
      .chr_full  (chr_full[i]),
      .chr_word  (chr_w[i]),
      .mark_pend (mark_pend[i]),
      .collide   (collide[i])
    );
  end

  rxs_pick #(.REQS(REQS)) u_pick (
    .req (req),
    .gnt (gnt),
    .idx (win),
    .any (any_req)
  );

  assign win_line  = win[IW-1:1];
  assign win_mark  = win[0];
  assign new_word  = make_word(ovr_q, win_mark, 3'(win_line), chr_w[win_line]);
  assign push      = any_req & ~full & ~master_clr;
  assign drop_full = any_req & full & ~master_clr;
  assign drop_any  = drop_full | (|collide);
  assign pop       = rd_stb & ~empty & ~master_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ovr_q <= 1'b0;
    else if (master_clr) ovr_q <= 1'b0;
    else                 ovr_q <= next_ovr(ovr_q, drop_any, push);
  end

  rxs_store #(.DEPTH(DEPTH), .W(WORD_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (master_clr),
    .push  (push),
    .din   (new_word),
    .pop   (pop),
    .dout  (head),
    .count (count),
    .empty (empty),
    .full  (full)
  );

  assign rd_data  = empty ? '0 : head;
  assign ctl_stat = {~empty, rx_ie, 6'b0};
  assign rx_irq   = rx_ie & ~empty;
endmodule

// File: rtl/rx_silo_hub_chk.sv
module rx_silo_hub_chk #(
  parameter int DEPTH = 64,
  parameter int REQS  = 16,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          master_clr,
  input logic          rd_stb,
  input logic [15:0]   rd_data,
  input logic          rx_irq,
  input logic [CW-1:0] count,
  input logic [REQS-1:0] gnt,
  input logic          push,
  input logic          pop,
  input logic          drop_any,
  input logic          ovr_q
);
  // R2: an empty store reads as zero
  a_r2_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> (rd_data == 16'h0));

  // R2: a pop alone lowers the fill level by one
  a_r2_pop_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (count == $past(count) - 1'b1));

  // R3: at most one requester wins per cycle
  a_r3_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R7: the fill level never passes the depth
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R7: a store without a new drop leaves the overrun flag clear
  a_r7_ovr_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !drop_any && !master_clr) |=> !ovr_q);

  // R1 and R9: a raised interrupt means the head word is valid
  a_r9_irq_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rd_data[15]);

  // R10: a clear leaves the store empty and the flag clear
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    master_clr |=> (count == '0 && !ovr_q));

  // R2: a strobe on an empty store changes nothing
  a_r2_empty_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && count == '0 && !push) |=> (count == '0));
endmodule

bind rx_silo_hub rx_silo_hub_chk #(.DEPTH(DEPTH), .REQS(REQS), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .master_clr (master_clr),
  .rd_stb     (rd_stb),
  .rd_data    (rd_data),
  .rx_irq     (rx_irq),
  .count      (count),
  .gnt        (gnt),
  .push       (push),
  .pop        (pop),
  .drop_any   (drop_any),
  .ovr_q      (ovr_q)
);

// File: tb/sim_rx_silo_hub.sv
`timescale 1ns/1ps
module sim_rx_silo_hub;
  localparam int NL = 8;
  localparam int DP = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          master_clr = 1'b0;
  logic [NL-1:0] rx_vld = '0, rx_perr = '0, rx_ferr = '0, rx_en = '0, dcd = '0, mdm_ie = '0;
  logic [NL*8-1:0] rx_data = '0;
  logic          rx_ie = 1'b0, rd_stb = 1'b0;
  logic [15:0]   rd_data;
  logic [7:0]    ctl_stat;
  logic          rx_irq;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_silo_hub u0 (
    .clk(clk), .rst_n(rst_n), .master_clr(master_clr), .rx_vld(rx_vld),
    .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_en(rx_en),
    .dcd(dcd), .mdm_ie(mdm_ie), .rx_ie(rx_ie), .rd_stb(rd_stb),
    .rd_data(rd_data), .ctl_stat(ctl_stat), .rx_irq(rx_irq)
  );

  // Reference model state
  bit          m_full [NL];
  logic [9:0]  m_chr  [NL];   // {fe, pe, ch}
  bit          m_pend [NL];
  bit          m_carq [NL];
  bit          m_ovr;
  logic [15:0] mq [$];

  function automatic logic [15:0] word_of(bit ovr, bit fe, bit pe, bit mark,
                                          int line, logic [7:0] ch);
    return 16'h8000 + (ovr ? 16'h4000 : 0) + (fe ? 16'h2000 : 0) + (pe ? 16'h1000 : 0)
         + (mark ? 16'h0800 : 0) + 16'(line * 256) + 16'(ch);
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit full_pre, dropped, stored;
    int win;
    full_pre = (mq.size() == DP);
    dropped = 0; stored = 0; win = -1;
    if (master_clr) begin
      mq.delete();
      foreach (m_full[i]) begin m_full[i] = 0; m_pend[i] = 0; m_carq[i] = dcd[i]; end
      m_ovr = 0;
      return;
    end
    if (rd_stb && mq.size() > 0) void'(mq.pop_front());
    for (int i = 0; i < NL && win < 0; i++) begin
      if (m_full[i]) win = 2 * i;
      else if (m_pend[i]) win = 2 * i + 1;
    end
    if (win >= 0) begin
      int ln = win / 2;
      bit mk = (win % 2) == 1;
      if (!full_pre) begin
        if (mk) mq.push_back(word_of(m_ovr, 0, 0, 1, ln, 8'h00));
        else    mq.push_back(word_of(m_ovr, m_chr[ln][9], m_chr[ln][8], 0, ln, m_chr[ln][7:0]));
        stored = 1;
      end else dropped = 1;
      if (mk) m_pend[ln] = 0; else m_full[ln] = 0;
    end
    for (int i = 0; i < NL; i++) begin
      if (rx_vld[i] && rx_en[i]) begin
        if (!m_full[i]) begin
          m_full[i] = 1;
          m_chr[i] = {rx_ferr[i], rx_perr[i], rx_data[i*8 +: 8]};
        end else dropped = 1;
      end
      if (mdm_ie[i] && (dcd[i] != m_carq[i])) m_pend[i] = 1;
      m_carq[i] = dcd[i];
    end
    m_ovr = dropped ? 1 : (stored ? 0 : m_ovr);
  endtask

  task automatic compare(string tag);
    logic [15:0] e;
    e = (mq.size() > 0) ? mq[0] : 16'h0;
    chk(tag, rd_data, e);
    chk("R9", 16'(rx_irq), 16'(rx_ie && mq.size() > 0));
    chk("R9", 16'(ctl_stat), 16'({mq.size() > 0, rx_ie, 6'b0}));
  endtask

  task automatic step(string tag = "R1");
    model_edge();
    @(posedge clk);
    @(negedge clk);
    rx_vld = '0; rd_stb = 0; master_clr = 0;
    compare(tag);
  endtask

  task automatic send(int line, logic [7:0] ch, bit pe, bit fe);
    rx_vld[line] = 1; rx_data[line*8 +: 8] = ch; rx_perr[line] = pe; rx_ferr[line] = fe;
  endtask

  task automatic drain_count(output int n, output logic [15:0] second);
    n = 0; second = 0;
    while (rd_data[15] && n < 200) begin
      if (n == 1) second = rd_data;
      n++; rd_stb = 1; step("R2");
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    int n;
    logic [15:0] w2;
    void'($urandom(32'h1234_5EED));
    foreach (m_full[i]) begin m_full[i] = 0; m_pend[i] = 0; m_carq[i] = 0; m_chr[i] = '0; end
    m_ovr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11", rd_data, 16'h0);
    chk("R11", 16'(rx_irq), 16'h0);
    chk("R11", 16'(ctl_stat), 16'h0);

    // R3 latency, R6 framing flag, R1 layout, R9 interrupt
    rx_ie = 1; rx_en = '1;
    send(3, 8'h41, 0, 1);
    step("R3");
    chk("R3", rd_data, 16'h0);
    step("R3");
    chk("R6", rd_data, 16'hA341);
    chk("R9", 16'(rx_irq), 16'h1);
    chk("R9", 16'(ctl_stat), 16'h00C0);

    // R2 pop, empty strobe has no effect
    rd_stb = 1; step("R2");
    chk("R2", rd_data, 16'h0);
    rd_stb = 1; step("R2");
    chk("R2", rd_data, 16'h0);
    send(2, 8'h7E, 1, 0); step("R2"); step("R2");
    chk("R2", rd_data, 16'h927E);
    rd_stb = 1; step("R2");

    // R3 ordering for same-cycle arrivals
    send(5, 8'h05, 0, 0); send(1, 8'h01, 0, 0); send(6, 8'h06, 0, 0);
    step("R3"); step("R3"); step("R3"); step("R3");
    chk("R3", rd_data, 16'h8101); rd_stb = 1; step("R3");
    chk("R3", rd_data, 16'h8505); rd_stb = 1; step("R3");
    chk("R3", rd_data, 16'h8606); rd_stb = 1; step("R3");

    // R5 disabled line ignored
    rx_en[2] = 0; send(2, 8'h22, 0, 0);
    step("R5"); step("R5"); step("R5");
    chk("R5", rd_data, 16'h0);
    rx_en[2] = 1;

    // R4 carrier markers
    mdm_ie[4] = 1; dcd[4] = 1; dcd[7] = 1;
    step("R4"); step("R4"); step("R4");
    chk("R4", rd_data, 16'h8C00);
    rd_stb = 1; step("R4");
    chk("R4", rd_data, 16'h0);

    // R7 fill to depth, drop, overrun placement
    for (int k = 0; k < 70; k++) begin send(0, 8'(k), 0, 0); step("R7"); end
    step("R7"); step("R7");
    chk("R7", 16'(ctl_stat[7]), 16'h1);
    for (int k = 0; k < DP; k++) begin
      chk("R7", rd_data, word_of(0, 0, 0, 0, 0, 8'(k)));
      rd_stb = 1; step("R7");
    end
    chk("R7", rd_data, 16'h0);
    send(0, 8'h55, 0, 0); step("R7"); step("R7");
    chk("R7", rd_data, 16'hC055);
    rd_stb = 1; step("R7");
    send(0, 8'h56, 0, 0); step("R7"); step("R7");
    chk("R7", rd_data, 16'h8056);
    rd_stb = 1; step("R7");

    // R8 holding register collision
    for (int i = 0; i < NL; i++) send(i, 8'(8'h10 + i), 0, 0);
    step("R8");
    for (int i = 0; i < NL; i++) send(i, 8'(8'h20 + i), 0, 0);
    step("R8");
    repeat (10) step("R8");
    drain_count(n, w2);
    chk("R8", 16'(n), 16'd9);
    chk("R8", w2, 16'hC020);

    // R10 master clear
    send(1, 8'h11, 0, 0); step("R10"); step("R10");
    for (int k = 0; k < 66; k++) begin send(6, 8'(k), 0, 0); step("R10"); end
    master_clr = 1; step("R10");
    chk("R10", rd_data, 16'h0);
    chk("R10", 16'(rx_irq), 16'h0);
    send(1, 8'h12, 0, 0); step("R10"); step("R10");
    chk("R10", rd_data, 16'h8112);
    rd_stb = 1; step("R10");

    // Random traffic against the model
    for (int c = 0; c < 4000; c++) begin
      int burst = (c / 500) % 2;
      rx_vld  = 8'($urandom) & 8'($urandom) & (burst ? 8'hFF : 8'($urandom));
      rx_data = {$urandom, $urandom};
      rx_perr = 8'($urandom) & 8'($urandom);
      rx_ferr = 8'($urandom) & 8'($urandom);
      if ($urandom_range(0, 15) == 0) dcd = 8'($urandom);
      if ($urandom_range(0, 63) == 0) mdm_ie = 8'($urandom);
      if ($urandom_range(0, 63) == 0) rx_en = 8'($urandom) | 8'h0F;
      if ($urandom_range(0, 99) == 0) rx_ie = ~rx_ie;
      rd_stb = burst ? ($urandom_range(0, 3) == 0) : ($urandom_range(0, 3) != 0);
      master_clr = ($urandom_range(0, 999) == 0);
      step("R3");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule